// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the 16x-oversampling enable tick that a serial transmitter and receiver use as their sampling reference. The tick is derived from the peripheral clock through a programmable fixed-point divisor. The divisor has a 16-bit integer part and a 6-bit fraction, so its value is `integer + fraction/64` clock cycles per tick. The resulting baud rate is `clk / (16 * (integer + fraction/64))`.

Each divisor part is loaded from a shared write-data bus when its own write strobe is high. Only the low bits of the bus that fit the part are kept.

The fraction is realised by dithering. Every tick period lasts either `integer` or `integer + 1` cycles. A 6-bit accumulator adds the fraction at the end of each period. A carry out of the accumulator makes the next period the longer one. As a result, the extra cycles are spread evenly and the average period equals the programmed value.

An integer part of zero stops the tick, and so does a low enable. Any divisor write restarts the period count from a clean state.

Top module: `baud_frac_tick`

## Requirements
- R1: After reset both divisor parts are zero, and no tick is produced even with `en` high.
- R2: With fraction 0 and integer part N >= 2, `tick` is high for exactly one cycle in every N cycles.
- R3: With integer part N and fraction F, numbering periods from 1 after a restart, period k lasts N + c(k) cycles. Here c(1) = 0, and c(k) = floor((k-1)F/64) - floor((k-2)F/64) for k >= 2. Any 64 consecutive periods starting at period 2 therefore sum to 64N + F cycles.
- R4: While the integer part is zero, `tick` stays low.
- R5: With integer part 1 and fraction 0, `tick` is high in every cycle while `en` is high.
- R6: A write to either divisor part clears the period counter and the fractional accumulator. The first tick then appears in the N-th cycle after the write edge, where cycle 1 is the cycle right after that edge. No tick is produced in the write cycle itself.
- R7: An integer write keeps only `wdata[15:0]`, and a fraction write keeps only `wdata[5:0]`. All other bus bits have no effect on the tick period.
- R8: While `en` is low no tick is produced and the counting state is cleared. After `en` rises, the first tick appears in the N-th cycle with `en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Tick generation enable |
| wdata | input | 32 | Shared write data for the divisor parts |
| int_we | input | 1 | Load integer divisor part from `wdata` |
| frac_we | input | 1 | Load fractional divisor part from `wdata` |
| tick | output | 1 | Single-cycle 16x baud enable |

## Verification
The bench builds the block with its default widths: a 16-bit integer part, a 6-bit fraction and a 32-bit write bus. With these widths, the fraction 63 puts a carry on almost every period. The fractions 21 and 32 give irregular and alternating stretch patterns. The widths also leave bus bits above both fields free, so they can be set to show that they are dropped. Integer values of 1, 2 and 3 keep every period short, so a run of 65 consecutive periods stays brief. That is long enough to show the whole accumulator cycle.

// File: rtl/baud_frac_tick.sv
module baud_frac_tick #(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 6,
  parameter int WDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [WDATA_W-1:0] wdata,
  input  logic               int_we,
  input  logic               frac_we,
  output logic               tick
);
  localparam int LAST_W = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q;
  logic [INT_W-1:0]  cnt_q;

  wire unused_hi = ^wdata[WDATA_W-1:INT_W];

  wire restart = int_we | frac_we;
  wire running = en && (int_q != '0);

  wire [LAST_W-1:0] last   = {1'b0, int_q} + {{INT_W{1'b0}}, stretch_q} - LAST_W'(1);
  wire              at_end = ({1'b0, cnt_q} == last);
  wire [FRAC_W:0]   acc_sum = {1'b0, acc_q} + {1'b0, frac_q};

  assign tick = running && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q     <= '0;
      frac_q    <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (int_we)  int_q  <= wdata[INT_W-1:0];
      if (frac_we) frac_q <= wdata[FRAC_W-1:0];
      if (restart || !running) begin
        cnt_q     <= '0;
        acc_q     <= '0;
        stretch_q <= 1'b0;
      end else if (at_end) begin
        cnt_q     <= '0;
        acc_q     <= acc_sum[FRAC_W-1:0];
        stretch_q <= acc_sum[FRAC_W];
      end else begin
        cnt_q <= cnt_q + INT_W'(1);
      end
    end
  end

  // R4
  no_tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0) |-> !tick);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && int_q > INT_W'(1) && en) |=> !tick);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ({1'b0, cnt_q} <= last));

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && acc_q == '0 && !stretch_q));

  // R5
  every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && int_q == INT_W'(1) && frac_q == '0 && en && !restart) |=> (tick || !en || restart));
endmodule

// File: tb/tb_baud_frac_tick.sv
module tb_baud_frac_tick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] wdata = '0;
  logic        int_we = 1'b0;
  logic        frac_we = 1'b0;
  logic        tick;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_frac_tick dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wdata(wdata),
    .int_we(int_we), .frac_we(frac_we), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit to_int, input logic [31:0] d);
    @(posedge clk); #1;
    wdata = d; int_we = to_int; frac_we = !to_int;
    @(posedge clk); #1;
    int_we = 1'b0; frac_we = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (tick) return;
    end
    n = -1;
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  function automatic int carry(input int k, input int f);
    if (k < 2) return 0;
    return ((k - 1) * f) / 64 - ((k - 2) * f) / 64;
  endfunction

  task automatic t_reset();
    int n;
    @(posedge clk); #1; en = 1'b1;
    count_ticks(60, n);
    chk(n == 0, "R1 no tick after reset", n, 0);
  endtask

  task automatic t_integer();
    int n;
    wr(0, 0);
    wr(1, 5);
    wait_tick(n);
    chk(n == 5, "R6 first tick after integer write", n, 5);
    for (int i = 0; i < 8; i++) begin
      wait_tick(n);
      chk(n == 5, "R2 integer period", n, 5);
    end
  endtask

  task automatic t_every();
    int n;
    wr(0, 0);
    wr(1, 1);
    count_ticks(20, n);
    chk(n == 20, "R5 tick every cycle", n, 20);
  endtask

  task automatic t_frac(input int ni, input int f);
    int n, sum;
    wr(1, ni);
    wr(0, f);
    sum = 0;
    for (int k = 1; k <= 65; k++) begin
      wait_tick(n);
      chk(n == ni + carry(k, f), "R3 dithered period", n, ni + carry(k, f));
      if (k >= 2) sum += n;
    end
    chk(sum == 64 * ni + f, "R3 64-period sum", sum, 64 * ni + f);
  endtask

  task automatic t_mask();
    int n;
    wr(1, 32'hABCD_0004);
    wr(0, 32'hFFFF_FFC0);
    for (int i = 0; i < 6; i++) begin
      wait_tick(n);
      chk(n == 4, "R7 upper bus bits dropped", n, 4);
    end
  endtask

  task automatic t_zero();
    int n;
    wr(1, 3);
    wait_tick(n);
    wr(1, 32'h0001_0000);
    count_ticks(80, n);
    chk(n == 0, "R4 zero integer stops tick", n, 0);
  endtask

  task automatic t_enable();
    int n;
    wr(0, 0);
    wr(1, 6);
    @(posedge clk); #1; en = 1'b0;
    count_ticks(40, n);
    chk(n == 0, "R8 no tick while disabled", n, 0);
    @(posedge clk); #1; en = 1'b1;
    wait_tick(n);
    chk(n == 6, "R8 first tick after enable", n, 6);
  endtask

  task automatic t_restart();
    int n;
    wr(0, 0);
    wr(1, 7);
    wait_tick(n);
    repeat (3) @(negedge clk);
    wr(0, 0);
    wait_tick(n);
    chk(n == 7, "R6 fraction write restarts period", n, 7);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_integer();
    t_every();
    t_frac(3, 21);
    t_frac(2, 63);
    t_frac(1, 32);
    t_mask();
    t_zero();
    t_enable();
    t_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule